// File: doc/BRIEF.md
# SMBus target with clock-low recovery and alert reply

This block is the two-wire serial target port of a monitoring device. It brings the SCL and SDA lines into the system clock domain, recognises START and STOP, and decodes the bytes on the bus. It drives SDA only through an open-drain enable and never drives SCL, so the host or another device may hold the clock low as long as it likes. Addressed writes load a register pointer and then store data bytes. Addressed reads return bytes from the pointer onward. The register space holds a few scratch bytes, a status byte and a configuration byte.

The block also drives the active-low alert line. Status bits latch on single-cycle event pulses. A monitoring-cycle strobe pulls the alert low when the interrupt enable is set and any status bit is set. The host finds the source by reading from the Alert Response Address. The block acknowledges only while it has an enabled, pending cause, and it answers with its own address. The acknowledge clears the interrupt enable, which releases the alert line. If SCL stays low for 30 ms the transfer is abandoned. A START followed directly by a STOP also returns the port to idle.

The protocol machine has seven states:
- **IDLE**: waits for START.
- **ADDR**: shifts in the address byte.
- **ACK**: drives the acknowledge bit.
- **RX**: shifts in a data byte.
- **TX**: shifts out a data byte.
- **RACK**: samples the host's acknowledge.
- **RNEXT**: waits for the clock fall that starts the next read byte.

The transitions are:
- START from any state goes to ADDR.
- STOP or a timeout from any state goes to IDLE.
- ADDR goes to ACK on a match and to IDLE on a miss.
- ACK goes to TX for a read and to RX for a write.
- RX goes to ACK after 8 bits.
- TX goes to RACK after 8 bits.
- RACK goes to RNEXT on a host ACK. It goes to IDLE on a NACK or after the alert reply.
- RNEXT goes to TX.

Top module: `smb_alert_target`

## Requirements
- R1: START (SDA falling while SCL is high, both lines passed through two flip-flops) enters ADDR from any state. STOP (SDA rising while SCL is high) enters IDLE and releases SDA. A START followed directly by a STOP leaves the block idle, changes no register, and has no effect on the next transfer.
- R2: The address byte is sent MSB first: 7 address bits, then the R/W bit (1 = read). An ordinary address is acknowledged (SDA held low during the 9th clock) only if it equals DEV_ADDR. Any other address gets no acknowledge.
- R3: In a write, the first data byte sets the register pointer. Each later byte is stored at the pointer, and the pointer then increments. Every data byte is acknowledged.
- R4: A read returns the byte at the pointer, MSB first, and increments the pointer. It goes on to the next byte while the host acknowledges and stops at a host NACK. A repeated START keeps the pointer.
- R5: Scratch bytes sit at addresses 0 to NREG-1. Status sits at 0x41 in bits NEV-1:0. Configuration sits at 0x7C, with bit 2 as the interrupt enable. Other addresses read 0 and ignore writes. Everything resets to 0.
- R6: Status bit i sets on a pulse of evt[i]. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: alert_n goes low only on a mon_strobe cycle where the interrupt enable is 1 and status is nonzero. It returns high one clock after either condition drops. It then stays high until a later strobe finds both conditions true again.
- R8: A read from address 0001100 is acknowledged only while the interrupt enable is 1 and status is nonzero. The reply byte is {DEV_ADDR, 0}. The acknowledge clears configuration bit 2 and leaves the other configuration bits unchanged.
- R9: If synchronised SCL stays low for TIMEOUT_MS × CLKS_PER_MS clocks (30 ms by default), the block releases SDA and enters IDLE. It is still driving at 25 ms and has released SDA by 35 ms. The next transfer works normally.
- R10: sda_oe changes only while synchronised SCL is low. The block has no SCL output. Transfers whose clock-low phases are stretched to different lengths give the same results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| evt | input | NEV | Status event pulses from the monitoring logic |
| mon_strobe | input | 1 | Monitoring-cycle strobe that may assert the alert |
| alert_n | output | 1 | Active-low alert line |

## Verification
The bit counter, shift register and pointer are all observable at the pins. A wrong bit count or a misplaced acknowledge shows on SDA during the very next 9th clock. A wrong pointer or a bad write shows in the first byte read back after it. The alert path is visible directly: a wrong enable or status latch shows on alert_n within one clock of the next strobe or of the write that should release it, and the configuration read after an alert reply shows whether bit 2 alone was cleared. A stuck non-idle state shows up after a timeout or a bus reset, when the next addressed transfer is not acknowledged.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_RX,
        ST_TX,
        ST_RACK,
        ST_RNEXT
    } smb_state_e;

    localparam logic [6:0] ALERT_REPLY_ADDR = 7'b0001100;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[STAGES-2:0], sda_in};
            scl_q  <= scl_ff[STAGES-1];
            sda_q  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s    = scl_ff[STAGES-1];
    assign sda_s    = sda_ff[STAGES-1];
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & ~sda_s & sda_q;
    assign stop_ev  = scl_s & scl_q & sda_s & ~sda_q;

endmodule

// File: rtl/smb_low_timer.sv
module smb_low_timer #(
    parameter int CLKS_PER_MS = 100000,
    parameter int LIMIT_MS    = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_low,
    output logic expire
);

    localparam int PW = $clog2(CLKS_PER_MS + 1);
    localparam int MW = $clog2(LIMIT_MS + 1);
    localparam logic [PW-1:0] PRE_LAST = PW'(CLKS_PER_MS - 1);
    localparam logic [MW-1:0] MS_LAST  = MW'(LIMIT_MS - 1);
    localparam logic [MW-1:0] MS_DONE  = MW'(LIMIT_MS);

    logic [PW-1:0] pre;
    logic [MW-1:0] ms;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre    <= '0;
            ms     <= '0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (!scl_low) begin
                pre <= '0;
                ms  <= '0;
            end else if (ms != MS_DONE) begin
                if (pre == PRE_LAST) begin
                    pre    <= '0;
                    ms     <= ms + 1'b1;
                    expire <= (ms == MS_LAST);
                end else begin
                    pre <= pre + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/smb_regs.sv
module smb_regs #(
    parameter int         NREG        = 4,
    parameter int         NEV         = 4,
    parameter logic [7:0] STATUS_ADDR = 8'h41,
    parameter logic [7:0] CFG_ADDR    = 8'h7C,
    parameter int         INTEN_BIT   = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [7:0]     addr,
    input  logic [7:0]     wr_data,
    output logic [7:0]     rd_data,
    input  logic [NEV-1:0] evt,
    input  logic           inten_clr,
    output logic           inten,
    output logic           status_any
);

    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

    logic [7:0]     scratch [NREG];
    logic [NEV-1:0] status;
    logic [7:0]     cfg;
    logic           wr_status, wr_cfg;

    assign wr_status = wr_en && (addr == STATUS_ADDR);
    assign wr_cfg    = wr_en && (addr == CFG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) scratch[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++)
                if (wr_en && addr == 8'(i)) scratch[i] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            cfg    <= '0;
        end else begin
            for (int i = 0; i < NEV; i++)
                status[i] <= evt[i] | (status[i] & ~(wr_status & wr_data[i]));
            if (inten_clr)
                cfg[INTEN_BIT] <= 1'b0;
            else if (wr_cfg)
                cfg <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(addr) < NREG)
            rd_data = scratch[addr[IW-1:0]];
        else if (addr == STATUS_ADDR)
            rd_data[NEV-1:0] = status;
        else if (addr == CFG_ADDR)
            rd_data = cfg;
    end

    assign inten      = cfg[INTEN_BIT];
    assign status_any = |status;

endmodule

// File: rtl/smb_alert_ctl.sv
module smb_alert_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_strobe,
    input  logic inten,
    input  logic status_any,
    output logic alert_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            alert_q <= 1'b0;
        else if (!inten || !status_any)
            alert_q <= 1'b0;
        else if (mon_strobe)
            alert_q <= 1'b1;
    end

endmodule

// File: rtl/smb_alert_target.sv
module smb_alert_target
    import smb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2E,
    parameter int         CLKS_PER_MS = 100000,
    parameter int         TIMEOUT_MS  = 30,
    parameter int         NREG        = 4,
    parameter int         NEV         = 4,
    parameter logic [7:0] STATUS_ADDR = 8'h41,
    parameter logic [7:0] CFG_ADDR    = 8'h7C,
    parameter int         INTEN_BIT   = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scl_in,
    input  logic           sda_in,
    output logic           sda_oe,
    input  logic [NEV-1:0] evt,
    input  logic           mon_strobe,
    output logic           alert_n
);

    localparam int              BCW       = 4;
    localparam logic [BCW-1:0]  BYTE_BITS = BCW'(8);

    smb_state_e     state, st_nx;
    logic           scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic           expire, abort, got8, byte_end;
    logic           addr_hit, ara_hit, inten_clr, reg_wr;
    logic           inten, status_any, alert_q;
    logic [7:0]     shreg, txbyte, ptr, rd_data, load_byte;
    logic [BCW-1:0] bitcnt;
    logic           rd_mode, ara_mode, have_ptr;

    smb_line_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    smb_low_timer #(.CLKS_PER_MS(CLKS_PER_MS), .LIMIT_MS(TIMEOUT_MS)) u_timer (
        .clk(clk), .rst_n(rst_n), .scl_low(~scl_s), .expire(expire)
    );

    smb_regs #(
        .NREG(NREG), .NEV(NEV), .STATUS_ADDR(STATUS_ADDR),
        .CFG_ADDR(CFG_ADDR), .INTEN_BIT(INTEN_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(ptr), .wr_data(shreg),
        .rd_data(rd_data), .evt(evt), .inten_clr(inten_clr),
        .inten(inten), .status_any(status_any)
    );

    smb_alert_ctl u_alert (
        .clk(clk), .rst_n(rst_n), .mon_strobe(mon_strobe),
        .inten(inten), .status_any(status_any), .alert_q(alert_q)
    );

    assign alert_n = ~alert_q;

    // decode of the current byte and side effects
    always_comb begin
        abort     = expire | stop_ev;
        got8      = (bitcnt == BYTE_BITS);
        byte_end  = scl_fall && got8;
        addr_hit  = (shreg[7:1] == DEV_ADDR);
        ara_hit   = !addr_hit && (shreg[7:1] == ALERT_REPLY_ADDR) && shreg[0]
                    && inten && status_any;
        inten_clr = !abort && !start_ev && (state == ST_ADDR) && byte_end && ara_hit;
        reg_wr    = !abort && !start_ev && (state == ST_RX) && byte_end && have_ptr;
        load_byte = ara_mode ? {DEV_ADDR, 1'b0} : rd_data;
    end

    // next state
    always_comb begin
        st_nx = state;
        if (abort)
            st_nx = ST_IDLE;
        else if (start_ev)
            st_nx = ST_ADDR;
        else begin
            unique case (state)
                ST_IDLE:  st_nx = ST_IDLE;
                ST_ADDR:  if (byte_end) st_nx = (addr_hit || ara_hit) ? ST_ACK : ST_IDLE;
                ST_ACK:   if (scl_fall) st_nx = rd_mode ? ST_TX : ST_RX;
                ST_RX:    if (byte_end) st_nx = ST_ACK;
                ST_TX:    if (byte_end) st_nx = ST_RACK;
                ST_RACK:  if (scl_rise) st_nx = (sda_s || ara_mode) ? ST_IDLE : ST_RNEXT;
                ST_RNEXT: if (scl_fall) st_nx = ST_TX;
                default:  st_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= st_nx;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe   <= 1'b0;
            shreg    <= '0;
            txbyte   <= '0;
            bitcnt   <= '0;
            ptr      <= '0;
            rd_mode  <= 1'b0;
            ara_mode <= 1'b0;
            have_ptr <= 1'b0;
        end else if (abort) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
        end else if (start_ev) begin
            sda_oe   <= 1'b0;
            bitcnt   <= '0;
            rd_mode  <= 1'b0;
            ara_mode <= 1'b0;
            have_ptr <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_end) begin
                        bitcnt <= '0;
                        if (addr_hit) begin
                            sda_oe  <= 1'b1;
                            rd_mode <= shreg[0];
                        end else if (ara_hit) begin
                            sda_oe   <= 1'b1;
                            rd_mode  <= 1'b1;
                            ara_mode <= 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (rd_mode) begin
                            sda_oe <= ~load_byte[7];
                            txbyte <= {load_byte[6:0], 1'b0};
                            bitcnt <= BCW'(1);
                            if (!ara_mode) ptr <= ptr + 1'b1;
                        end else begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_end) begin
                        sda_oe   <= 1'b1;
                        bitcnt   <= '0;
                        have_ptr <= 1'b1;
                        ptr      <= have_ptr ? ptr + 1'b1 : shreg;
                    end
                end
                ST_TX: begin
                    if (byte_end) begin
                        sda_oe <= 1'b0;
                    end else if (scl_fall) begin
                        sda_oe <= ~txbyte[7];
                        txbyte <= {txbyte[6:0], 1'b0};
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                ST_RNEXT: begin
                    if (scl_fall) begin
                        sda_oe <= ~rd_data[7];
                        txbyte <= {rd_data[6:0], 1'b0};
                        bitcnt <= BCW'(1);
                        ptr    <= ptr + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/smb_alert_chk.sv
module smb_alert_chk
    import smb_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       alert_n,
    input logic       mon_strobe,
    input logic       inten,
    input logic       status_any,
    input logic       inten_clr,
    input logic       sda_oe,
    input logic       scl_s,
    input logic       stop_ev,
    input logic       expire,
    input smb_state_e state
);

    // R7
    alert_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alert_n |-> $past(inten && status_any));

    // R7
    alert_falls_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alert_n) |-> $past(mon_strobe));

    // R8
    ara_clears_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inten_clr |=> !inten);

    // R9
    timeout_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (!sda_oe && state == ST_IDLE));

    // R1
    stop_goes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (!sda_oe && state == ST_IDLE));

    // R10
    sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s));

endmodule

bind smb_alert_target smb_alert_chk u_chk (
    .clk(clk), .rst_n(rst_n), .alert_n(alert_n), .mon_strobe(mon_strobe),
    .inten(inten), .status_any(status_any), .inten_clr(inten_clr),
    .sda_oe(sda_oe), .scl_s(scl_s), .stop_ev(stop_ev), .expire(expire),
    .state(state)
);

// File: tb/sim_smb_alert_target.sv
`timescale 1ns/1ps
module sim_smb_alert_target;

    localparam logic [6:0] DEV = 7'h2E;
    localparam logic [6:0] ARA = 7'b0001100;
    localparam int CPM = 10;
    localparam int Q   = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       host_low = 1'b0;
    logic [3:0] evt = '0;
    logic       strobe = 1'b0;
    logic       sda_oe, alert_n, sda_line;
    int         total = 0, bad = 0, st_g = 1;

    always #2.5 clk = ~clk;
    assign sda_line = !(host_low || sda_oe);

    smb_alert_target #(.DEV_ADDR(DEV), .CLKS_PER_MS(CPM), .TIMEOUT_MS(30), .NREG(4), .NEV(4)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe),
        .evt(evt), .mon_strobe(strobe), .alert_n(alert_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        host_low = 1'b0; wq(Q); scl = 1'b1; wq(Q);
        host_low = 1'b1; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop;
        scl = 1'b0; host_low = 1'b1; wq(Q);
        scl = 1'b1; wq(Q); host_low = 1'b0; wq(Q);
    endtask

    task automatic send_bit(input logic b);
        host_low = !b; wq(Q * st_g); scl = 1'b1; wq(2 * Q); scl = 1'b0; wq(Q);
    endtask

    task automatic recv_bit(output logic b);
        host_low = 1'b0; wq(Q * st_g); scl = 1'b1; wq(Q); b = sda_line; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic wbyte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = !b;
    endtask

    task automatic rbyte(input logic nack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
        send_bit(nack);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        logic k;
        bus_start; wbyte({DEV, 1'b0}, k); wbyte(a, k); wbyte(d, k); bus_stop;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        logic k;
        bus_start; wbyte({DEV, 1'b0}, k); wbyte(a, k);
        bus_start; wbyte({DEV, 1'b1}, k); rbyte(1'b1, d); bus_stop;
    endtask

    task automatic pulse_strobe;
        strobe = 1'b1; wq(1); strobe = 1'b0; wq(3);
    endtask

    task automatic pulse_evt(input logic [3:0] e);
        evt = e; wq(1); evt = '0; wq(3);
    endtask

    function automatic logic [7:0] pat(input int p, input int i);
        return 8'h5A ^ 8'((p * 16 + i) * 37);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic       k;
        logic [7:0] d;
        wq(5); rst_n = 1'b1; wq(5);

        // R5 reset state
        check("R5 reset sda_oe", sda_oe, 0);
        check("R7 reset alert_n", alert_n, 1);
        rd_reg(8'h7C, d); check("R5 reset cfg", d, 8'h00);
        rd_reg(8'h41, d); check("R6 reset status", d, 8'h00);

        // R2 address sweep
        for (int a = 0; a < 128; a++) begin
            bus_start; wbyte({7'(a), 1'b0}, k); bus_stop;
            check($sformatf("R2 addr %0h ack", a), k, (7'(a) == DEV));
        end

        // R3 R4 R10 pointer sweep with varied clock stretching
        for (int p = 0; p < 4; p++) begin
            st_g = 1 + 2 * p;
            bus_start; wbyte({DEV, 1'b0}, k); wbyte(8'(p), k);
            for (int i = p; i < 4; i++) begin
                wbyte(pat(p, i), k); check("R3 data ack", k, 1);
            end
            bus_stop;
            bus_start; wbyte({DEV, 1'b0}, k); wbyte(8'(p), k);
            bus_start; wbyte({DEV, 1'b1}, k); check("R4 read addr ack", k, 1);
            for (int i = p; i < 4; i++) begin
                rbyte(i == 3, d);
                check($sformatf("R4 R10 read p%0d i%0d", p, i), d, pat(p, i));
            end
            bus_stop;
        end
        st_g = 1;

        // R5 unmapped address
        wr_reg(8'h20, 8'hFF); rd_reg(8'h20, d); check("R5 unmapped reads 0", d, 0);
        rd_reg(8'h01, d); check("R5 scratch kept", d, pat(1, 1));

        // R6 status latch and write-one-to-clear
        pulse_evt(4'b0101); rd_reg(8'h41, d); check("R6 latch", d, 8'h05);
        wr_reg(8'h41, 8'h01); rd_reg(8'h41, d); check("R6 w1c", d, 8'h04);
        pulse_evt(4'b1000); rd_reg(8'h41, d); check("R6 accumulate", d, 8'h0C);
        wr_reg(8'h41, 8'h0F); rd_reg(8'h41, d); check("R6 clear all", d, 8'h00);

        // R7 R8 alert flow
        wr_reg(8'h7C, 8'h84); pulse_strobe; check("R7 no status no alert", alert_n, 1);
        bus_start; wbyte({ARA, 1'b1}, k); bus_stop; check("R8 nack without status", k, 0);
        pulse_evt(4'b0010); check("R7 waits for strobe", alert_n, 1);
        pulse_strobe; check("R7 alert asserted", alert_n, 0);
        wr_reg(8'h7C, 8'h80); check("R7 released by enable", alert_n, 1);
        bus_start; wbyte({ARA, 1'b1}, k); bus_stop; check("R8 nack without enable", k, 0);
        pulse_strobe; check("R7 stays released", alert_n, 1);
        wr_reg(8'h7C, 8'h84); check("R7 no alert before strobe", alert_n, 1);
        pulse_strobe; check("R7 alert again", alert_n, 0);
        bus_start; wbyte({ARA, 1'b1}, k); check("R8 ara ack", k, 1);
        check("R8 alert released on ack", alert_n, 1);
        rbyte(1'b1, d); bus_stop; check("R8 reply byte", d, {DEV, 1'b0});
        rd_reg(8'h7C, d); check("R8 enable bit cleared", d, 8'h80);
        pulse_strobe; check("R7 no alert with enable off", alert_n, 1);
        wr_reg(8'h7C, 8'h04); pulse_strobe; check("R7 re-armed", alert_n, 0);
        wr_reg(8'h41, 8'h02); check("R7 released by status clear", alert_n, 1);

        // R9 clock low timeout during the acknowledge
        bus_start;
        for (int i = 7; i >= 0; i--) send_bit(DEV[i > 0 ? i - 1 : 0] & (i > 0));
        host_low = 1'b0;
        wq(240); check("R9 driving at 25ms", sda_oe, 1);
        wq(110); check("R9 released by 35ms", sda_oe, 0);
        scl = 1'b1; wq(Q); bus_stop;
        wr_reg(8'h02, 8'hC3); rd_reg(8'h02, d); check("R9 works after timeout", d, 8'hC3);

        // R1 bus reset: START then STOP with SCL high, mid-byte abort
        bus_start; wbyte({DEV, 1'b0}, k);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        host_low = 1'b1; scl = 1'b0; wq(Q);
        host_low = 1'b0; wq(Q); scl = 1'b1; wq(Q);
        host_low = 1'b1; wq(Q); host_low = 1'b0; wq(Q);
        check("R1 released after start-stop", sda_oe, 0);
        rd_reg(8'h02, d); check("R1 regs kept", d, 8'hC3);
        bus_start; wbyte({DEV, 1'b0}, k); check("R1 next transfer acked", k, 1); bus_stop;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule